// File: doc/BRIEF.md
# Quadrature-Sample Phase and Frequency Detector for a Full-Rate Clock Recovery Loop

This block is the digital decision logic of a full-rate clock and data recovery loop that has no local reference clock. On every transition of the incoming serial data, an edge sampler captures two bits: `samp_i`, the in-phase (0°) recovered clock, and `samp_q`, the quadrature (90°) clock. The block turns these sample pairs into four charge-pump drive levels. The phase pair follows the in-phase sample directly. The frequency pair is set and cleared by the direction in which the two-bit quadrant code rotates from one data edge to the next.

Edge events come in as single-cycle strobes on a fast system clock. All outputs are registered. They change only in the cycle after a strobe, so the loop filter model sees a stable level between data edges.

The quadrant code is {samp_i, samp_q}, with samp_i as bit 1. The quadrant tracker keeps the previous code in a state machine. Its states are QS_NONE (no edge seen since reset), QS_00, QS_01, QS_11 and QS_10. Every strobe moves it to the state that names the current code. With the VCO slow, the code rotates QS_00 → QS_01 → QS_11 → QS_10 → QS_00. With the VCO fast, it rotates the other way.

The frequency state machine has the states FS_IDLE, FS_UP and FS_DN, with these transitions:
- set-up: step 10→00 moves to FS_UP from any state.
- set-down: step 01→00 moves to FS_DN from any state.
- clear-up: FS_UP → FS_IDLE on a strobe with samp_q = 1.
- clear-down: FS_DN → FS_IDLE on a strobe with samp_i = 1.
- hold: any other strobe keeps the current state.

Top module: `qcdr_pfd_top`

## Requirements
- R1: While `rst` is high at a clock edge, all four outputs are 0 after that edge, and the stored quadrant returns to "none seen".
- R2: One cycle after a strobe, `ph_up` equals the `samp_i` of that strobe and `ph_dn` equals its inverse.
- R3: On cycles with `edge_stb` low, all four outputs keep their values, whatever the sample inputs do.
- R4: The first strobe after reset only stores the quadrant code and updates the phase outputs. `fr_up` and `fr_dn` stay 0.
- R5: A strobe whose code {samp_i,samp_q} is 2'b00, after a stored code of 2'b10 (the VCO-slow step), drives `fr_up` to 1 and `fr_dn` to 0.
- R6: Without a set condition, a strobe with `samp_q` = 1 clears `fr_up`.
- R7: A strobe whose code is 2'b00, after a stored code of 2'b01 (the VCO-fast step), drives `fr_dn` to 1 and `fr_up` to 0.
- R8: Without a set condition, a strobe with `samp_i` = 1 clears `fr_dn`.
- R9: `fr_up` and `fr_dn` are never high together. If both set conditions were to hold on one strobe, neither flag would be set.
- R10: Every other strobe leaves the frequency flags unchanged. This covers a repeated code, a diagonal step and the other rotation steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| edge_stb | input | 1 | Single-cycle strobe marking a serial data transition |
| samp_i | input | 1 | In-phase (0°) clock sample taken at the data edge |
| samp_q | input | 1 | Quadrature (90°) clock sample taken at the data edge |
| ph_up | output | 1 | Phase-up drive level |
| ph_dn | output | 1 | Phase-down drive level |
| fr_up | output | 1 | Frequency-up drive level (VCO too slow) |
| fr_dn | output | 1 | Frequency-down drive level (VCO too fast) |

## Verification
The assertions assume that `samp_i` and `samp_q` are valid in every cycle where `edge_stb` is high. They also assume that a strobe lasts exactly one system clock. Nothing is assumed about the samples when no strobe is present, and the hold property depends on that. The stimulus drives the samples and the strobe together on the falling clock edge and lowers the strobe one cycle later. In the gaps between strobes it toggles the sample inputs freely, which tests that they are ignored. The sweep covers every stored quadrant, every next code and every starting flag state.

// File: rtl/qcdr_pfd_pkg.sv
package qcdr_pfd_pkg;

    localparam int CODE_W = 2;

    typedef enum logic [2:0] {
        QS_NONE = 3'd0,
        QS_00   = 3'd1,
        QS_01   = 3'd2,
        QS_11   = 3'd3,
        QS_10   = 3'd4
    } quad_state_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_UP   = 2'd1,
        FS_DN   = 2'd2
    } freq_state_t;

    function automatic quad_state_t code_to_state(input logic [CODE_W-1:0] code);
        quad_state_t s;
        unique case (code)
            2'b00:   s = QS_00;
            2'b01:   s = QS_01;
            2'b11:   s = QS_11;
            default: s = QS_10;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/qcdr_quad_track.sv
module qcdr_quad_track
    import qcdr_pfd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                edge_stb,
    input  logic [CODE_W-1:0]   code,
    output quad_state_t         prev_state
);

    quad_state_t state_q;
    quad_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (edge_stb) begin
            unique case (code)
                2'b00:   state_d = QS_00;
                2'b01:   state_d = QS_01;
                2'b11:   state_d = QS_11;
                default: state_d = QS_10;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= QS_NONE;
        else     state_q <= state_d;
    end

    assign prev_state = state_q;

    // R4
    stored_follows_code_chk: assert property (@(posedge clk) disable iff (rst)
        edge_stb |=> (state_q == code_to_state($past(code))));

endmodule

// File: rtl/qcdr_rot_decode.sv
module qcdr_rot_decode
    import qcdr_pfd_pkg::*;
(
    input  quad_state_t         prev_state,
    input  logic [CODE_W-1:0]   code,
    output logic                slow_step,
    output logic                fast_step
);

    always_comb begin
        slow_step = 1'b0;
        fast_step = 1'b0;
        unique case (prev_state)
            QS_10:   slow_step = (code == 2'b00);
            QS_01:   fast_step = (code == 2'b00);
            QS_00,
            QS_11,
            QS_NONE: ;
            default: ;
        endcase
    end

    // R9
    step_exclusive_chk: assert final (!(slow_step && fast_step));

endmodule

// File: rtl/qcdr_freq_fsm.sv
module qcdr_freq_fsm
    import qcdr_pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic edge_stb,
    input  logic slow_step,
    input  logic fast_step,
    input  logic samp_i,
    input  logic samp_q,
    output logic fr_up,
    output logic fr_dn
);

    freq_state_t state_q;
    freq_state_t state_d;
    logic        set_up;
    logic        set_dn;

    assign set_up = slow_step && !fast_step;
    assign set_dn = fast_step && !slow_step;

    always_comb begin
        state_d = state_q;
        if (edge_stb) begin
            unique case (state_q)
                FS_IDLE: begin
                    if (set_up)      state_d = FS_UP;
                    else if (set_dn) state_d = FS_DN;
                end
                FS_UP: begin
                    if (set_dn)      state_d = FS_DN;
                    else if (set_up) state_d = FS_UP;
                    else if (samp_q) state_d = FS_IDLE;
                end
                FS_DN: begin
                    if (set_up)      state_d = FS_UP;
                    else if (set_dn) state_d = FS_DN;
                    else if (samp_i) state_d = FS_IDLE;
                end
                default: state_d = FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        fr_up = 1'b0;
        fr_dn = 1'b0;
        unique case (state_q)
            FS_UP:   fr_up = 1'b1;
            FS_DN:   fr_dn = 1'b1;
            default: ;
        endcase
    end

    // R9
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(fr_up && fr_dn));
    // R5
    up_set_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_stb && slow_step) |=> (fr_up && !fr_dn));
    // R7
    dn_set_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_stb && fast_step) |=> (fr_dn && !fr_up));
    // R6
    up_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_stb && samp_q && !slow_step) |=> !fr_up);
    // R8
    dn_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_stb && samp_i && !fast_step) |=> !fr_dn);

endmodule

// File: rtl/qcdr_phase_out.sv
module qcdr_phase_out (
    input  logic clk,
    input  logic rst,
    input  logic edge_stb,
    input  logic samp_i,
    output logic ph_up,
    output logic ph_dn
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_up <= 1'b0;
            ph_dn <= 1'b0;
        end else if (edge_stb) begin
            ph_up <= samp_i;
            ph_dn <= !samp_i;
        end
    end

    // R2
    phase_follow_chk: assert property (@(posedge clk) disable iff (rst)
        edge_stb |=> (ph_up == $past(samp_i)) && (ph_dn == !$past(samp_i)));

endmodule

// File: rtl/qcdr_pfd_top.sv
module qcdr_pfd_top
    import qcdr_pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic edge_stb,
    input  logic samp_i,
    input  logic samp_q,
    output logic ph_up,
    output logic ph_dn,
    output logic fr_up,
    output logic fr_dn
);

    logic [CODE_W-1:0] code;
    quad_state_t       prev_state;
    logic              slow_step;
    logic              fast_step;

    assign code = {samp_i, samp_q};

    qcdr_quad_track track_i (
        .clk        (clk),
        .rst        (rst),
        .edge_stb   (edge_stb),
        .code       (code),
        .prev_state (prev_state)
    );

    qcdr_rot_decode decode_i (
        .prev_state (prev_state),
        .code       (code),
        .slow_step  (slow_step),
        .fast_step  (fast_step)
    );

    qcdr_freq_fsm freq_i (
        .clk       (clk),
        .rst       (rst),
        .edge_stb  (edge_stb),
        .slow_step (slow_step),
        .fast_step (fast_step),
        .samp_i    (samp_i),
        .samp_q    (samp_q),
        .fr_up     (fr_up),
        .fr_dn     (fr_dn)
    );

    qcdr_phase_out phase_i (
        .clk      (clk),
        .rst      (rst),
        .edge_stb (edge_stb),
        .samp_i   (samp_i),
        .ph_up    (ph_up),
        .ph_dn    (ph_dn)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !ph_up && !ph_dn && !fr_up && !fr_dn);
    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !edge_stb |=> $stable({ph_up, ph_dn, fr_up, fr_dn}));
    // R4
    first_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_stb && prev_state == QS_NONE) |=> !fr_up && !fr_dn);

endmodule

// File: tb/qcdr_pfd_top_tb_top.sv
module qcdr_pfd_top_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b0;
    logic edge_stb = 1'b0;
    logic samp_i = 1'b0;
    logic samp_q = 1'b0;
    logic ph_up, ph_dn, fr_up, fr_dn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    bit       m_have;
    bit [1:0] m_prev;
    bit       m_ph_up, m_ph_dn, m_up, m_dn;

    always #10 clk = ~clk;

    qcdr_pfd_top dut_i (
        .clk(clk), .rst(rst), .edge_stb(edge_stb),
        .samp_i(samp_i), .samp_q(samp_q),
        .ph_up(ph_up), .ph_dn(ph_dn), .fr_up(fr_up), .fr_dn(fr_dn)
    );

    task automatic check_outs(input string req);
        bit [3:0] act, exp;
        act = {ph_up, ph_dn, fr_up, fr_dn};
        exp = {m_ph_up, m_ph_dn, m_up, m_dn};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {ph_up,ph_dn,fr_up,fr_dn} actual=%b expected=%b", req, act, exp);
        end
        checks++;
        if (fr_up && fr_dn) begin
            errors++;
            $display("FAIL R9: both frequency flags high actual=11 expected=not 11");
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        edge_stb = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        m_have = 0; m_prev = 2'b00;
        m_ph_up = 0; m_ph_dn = 0; m_up = 0; m_dn = 0;
        check_outs("R1");
    endtask

    task automatic do_edge(input bit [1:0] c);
        string req;
        bit su, sd;
        @(negedge clk);
        samp_i = c[1];
        samp_q = c[0];
        edge_stb = 1'b1;
        su = m_have && (m_prev == 2'b10) && (c == 2'b00);
        sd = m_have && (m_prev == 2'b01) && (c == 2'b00);
        req = "R10";
        if (!m_have) req = "R4";
        if (su && !sd) begin
            m_up = 1; m_dn = 0; req = "R5";
        end else if (sd && !su) begin
            m_dn = 1; m_up = 0; req = "R7";
        end else begin
            if (m_up && c[0]) begin m_up = 0; req = "R6"; end
            if (m_dn && c[1]) begin m_dn = 0; req = "R8"; end
        end
        m_ph_up = c[1];
        m_ph_dn = !c[1];
        m_have = 1;
        m_prev = c;
        @(negedge clk);
        edge_stb = 1'b0;
        check_outs(req);
        checks++;
        if (ph_up !== c[1] || ph_dn !== !c[1]) begin
            errors++;
            $display("FAIL R2: ph_up=%b ph_dn=%b expected %b %b", ph_up, ph_dn, c[1], !c[1]);
        end
    endtask

    task automatic idle_gap(input int n);
        for (int k = 0; k < n; k++) begin
            samp_i = k[0];
            samp_q = ~k[1];
            @(negedge clk);
            check_outs("R3");
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        do_reset();
        // directed slow rotation (VCO slow): 00,01,11,10,00 -> fr_up
        do_edge(2'b00); do_edge(2'b01); do_edge(2'b11);
        do_edge(2'b10); do_edge(2'b00);
        idle_gap(4);
        do_edge(2'b01);
        // directed fast rotation: 00,10,11,01,00 -> fr_dn
        do_edge(2'b00); do_edge(2'b10); do_edge(2'b11);
        do_edge(2'b01); do_edge(2'b00);
        idle_gap(4);
        do_edge(2'b10);
        // reset while a flag is high
        do_edge(2'b01); do_edge(2'b00);
        do_reset();
        // sweep: start flag x stored code x next code
        for (int f = 0; f < 3; f++) begin
            for (int p = 0; p < 4; p++) begin
                for (int c = 0; c < 4; c++) begin
                    do_reset();
                    if (f == 0) begin
                        do_edge(2'b11);
                    end else if (f == 1) begin
                        do_edge(2'b10); do_edge(2'b00);
                    end else begin
                        do_edge(2'b01); do_edge(2'b00);
                    end
                    do_edge(p[1:0]);
                    idle_gap(2);
                    do_edge(c[1:0]);
                    do_edge(2'b00);
                end
            end
        end
        // long pseudo-random walk with gaps
        begin
            bit [7:0] lfsr = 8'hA5;
            do_reset();
            for (int n = 0; n < 300; n++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                do_edge(lfsr[1:0]);
                if (lfsr[6]) idle_gap(1);
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule